// File: doc/BRIEF.md
# NAND Flash Controller Register Front End

This block is the register face of a NAND flash controller. Software reaches it through a plain 32-bit register bus and finds:
- a control word that holds a run bit and twelve interrupt masks;
- two timing words that are passed through to the pin sequencer;
- a status word whose event bits stay set until software clears them;
- a command port that takes a three-word command through one address.

The block combines the unmasked status bits into one interrupt line. It hands each complete command to the command sequencer over a valid/ready pair.

A command cycle starts when software sets the run bit. On that edge the block raises its write-command request in status bit 0. Software then writes the three command words in turn. Once the third word is in, the words are presented to the sequencer. When the sequencer accepts them, the request bit drops. Clearing the run bit abandons whatever command is in progress and returns the block to idle.

The sequencer reports its events (ready, command done, bad block, ECC results, data requests) as single-cycle pulses on an event input. The NAND pin protocol, ECC, DMA and data storage live elsewhere. The data buffer address reads as zero here.

Top module: `nand_reg_front`

## Requirements
- R1: After reset:
  - the control word at 0x00 reads 0x00000FFF: run bit 28 clear, all twelve masks in bits 11:0 set;
  - the status word at 0x14 reads 0;
  - both timing words read 0;
  - the interrupt is low.
- R2: The control word (0x00) and the timing words (0x04, 0x0C) are full 32-bit read/write registers. The timing words drive the `timing0` and `timing1` outputs.
- R3: A pulse on `evt_set[k]`, k from 1 to 11, sets status bit k, and the bit stays set. Status bit 0 is owned by the block, so `evt_set[0]` has no effect.
- R4: Writing a 1 to status bits 11:0 at 0x14 clears them, and writing 0 leaves them alone. When an event sets a bit in the same cycle as software clears it, the set wins.
- R5: `irq` is high exactly when some status bit k in 11:0 is 1 while control bit k is 0. A mask bit of 1 disables that source.
- R6: Status bit 0 (write-command request) is set on the edge that writes the control word with bit 28 going from 0 to 1. It never rises while the run bit is clear.
- R7: A command write is accepted only while status bit 0 is 1 and no command is already loaded or presented. Command writes go to 0x48, or to its aliases 0x4C and 0x50. Accepted writes fill word 0, then word 1, then word 2, whatever alias is used. The words read back at 0x48, 0x4C and 0x50.
- R8: After the edge that accepts the third word, `cmd_valid` is high with the three words on `cmd_word0..2`. It stays high, with the words stable, until `cmd_ready` is sampled high. On that edge `cmd_valid` falls and status bit 0 clears.
- R9: A rejected command write leaves the words unchanged and sets a sticky error flag at status bit 31. Writing 1 to bit 31 clears the flag. A new rejection in the same cycle wins over the clear.
- R10: Writing the control word with bit 28 going from 1 to 0 drops `cmd_valid`, clears status bit 0 and discards any partial load. The next run starts again at word 0.
- R11: Other addresses, including the data buffer at 0x40, read as zero. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_set | input | 12 | Status event pulses from the sequencer |
| irq | output | 1 | Interrupt request |
| run | output | 1 | Run bit of the control word |
| timing0 | output | 32 | First timing word |
| timing1 | output | 32 | Second timing word |
| cmd_valid | output | 1 | A complete command is presented |
| cmd_ready | input | 1 | Sequencer accepts the command |
| cmd_word0 | output | 32 | Command word 0 |
| cmd_word1 | output | 32 | Command word 1 |
| cmd_word2 | output | 32 | Command word 2 |

## Verification
The assertions assume that the sequencer pulses `evt_set` without regard to bit 0, and that `cmd_ready` may arrive at any time. They also assume that the bus performs at most one write per cycle, with the address held stable through it. The stimulus drives every input on the falling edge and uses single-cycle write strobes. It raises `cmd_ready` only for isolated cycles, both while a command is presented and while none is. This way the hold-until-ready and abort paths are reached without depending on the handshake arriving early.

// File: rtl/nand_reg_front.sv
module nand_reg_front #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [11:0]       evt_set,
  output logic              irq,
  output logic              run,
  output logic [31:0]       timing0,
  output logic [31:0]       timing1,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [31:0]       cmd_word0,
  output logic [31:0]       cmd_word1,
  output logic [31:0]       cmd_word2
);

  localparam int RUN_BIT = 28;
  localparam int ERR_BIT = 31;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_TIM0 = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_TIM1 = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] A_CB0  = ADDR_W'(8'h48);
  localparam logic [ADDR_W-1:0] A_CB1  = ADDR_W'(8'h4C);
  localparam logic [ADDR_W-1:0] A_CB2  = ADDR_W'(8'h50);

  typedef enum logic [1:0] {PH_IDLE, PH_LOAD, PH_SEND, PH_BUSY} phase_t;

  logic [31:0] ctrl;
  logic [11:0] stat, stat_nx;
  logic        err;
  phase_t      ph;
  logic [1:0]  cnt;

  wire wr_ctrl  = bus_wr && bus_addr == A_CTRL;
  wire wr_stat  = bus_wr && bus_addr == A_STAT;
  wire cmd_hit  = bus_wr && (bus_addr == A_CB0 || bus_addr == A_CB1 || bus_addr == A_CB2);
  wire run_rise = wr_ctrl &&  bus_wdata[RUN_BIT] && !ctrl[RUN_BIT];
  wire run_fall = wr_ctrl && !bus_wdata[RUN_BIT] &&  ctrl[RUN_BIT];
  wire accept   = cmd_hit && stat[0] && ph == PH_LOAD;
  wire hs       = ph == PH_SEND && cmd_ready;

  assign run       = ctrl[RUN_BIT];
  assign cmd_valid = ph == PH_SEND;
  assign irq       = |(stat & ~ctrl[11:0]);

  always_comb begin
    stat_nx = stat & ~(wr_stat ? bus_wdata[11:0] : 12'h000);
    stat_nx[11:1] = stat_nx[11:1] | evt_set[11:1];
    if (hs || run_fall) stat_nx[0] = 1'b0;
    if (run_rise)       stat_nx[0] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl      <= 32'h0000_0FFF;
      timing0   <= '0;
      timing1   <= '0;
      stat      <= '0;
      err       <= 1'b0;
      ph        <= PH_IDLE;
      cnt       <= '0;
      cmd_word0 <= '0;
      cmd_word1 <= '0;
      cmd_word2 <= '0;
    end else begin
      stat <= stat_nx;
      if (wr_ctrl) ctrl <= bus_wdata;
      if (bus_wr && bus_addr == A_TIM0) timing0 <= bus_wdata;
      if (bus_wr && bus_addr == A_TIM1) timing1 <= bus_wdata;
      if (cmd_hit && !accept)             err <= 1'b1;
      else if (wr_stat && bus_wdata[ERR_BIT]) err <= 1'b0;
      if (run_fall) begin
        ph  <= PH_IDLE;
        cnt <= '0;
      end else if (run_rise) begin
        ph  <= PH_LOAD;
        cnt <= '0;
      end else if (accept) begin
        case (cnt)
          2'd0:    cmd_word0 <= bus_wdata;
          2'd1:    cmd_word1 <= bus_wdata;
          default: cmd_word2 <= bus_wdata;
        endcase
        if (cnt == 2'd2) begin
          ph  <= PH_SEND;
          cnt <= '0;
        end else begin
          cnt <= cnt + 2'd1;
        end
      end else if (hs) begin
        ph <= PH_BUSY;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = ctrl;
      A_TIM0:  bus_rdata = timing0;
      A_TIM1:  bus_rdata = timing1;
      A_STAT:  bus_rdata = {err, 19'd0, stat};
      A_CB0:   bus_rdata = cmd_word0;
      A_CB1:   bus_rdata = cmd_word1;
      A_CB2:   bus_rdata = cmd_word2;
      default: bus_rdata = '0;
    endcase
  end

  a_r8_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready && !run_fall |=> cmd_valid && $stable(cmd_word0) && $stable(cmd_word1) && $stable(cmd_word2));

  a_r8_handoff_clears_req: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && !run_fall |=> !cmd_valid && !stat[0]);

  a_r10_stop_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    run_fall |=> !cmd_valid && !stat[0] && !run);

  a_r6_req_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[0]) |-> run);

  a_r9_err_from_cmd_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(cmd_hit));

  a_r10_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !cmd_valid);

endmodule

// File: tb/test_nand_reg_front.sv
module test_nand_reg_front;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [11:0] evt_set = '0;
  logic        irq, run, cmd_valid;
  logic        cmd_ready = 1'b0;
  logic [31:0] timing0, timing1, cmd_word0, cmd_word1, cmd_word2;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  nand_reg_front #(.ADDR_W(8)) i_nand_reg_front (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_set(evt_set),
    .irq(irq), .run(run), .timing0(timing0), .timing1(timing1),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word0(cmd_word0), .cmd_word1(cmd_word1), .cmd_word2(cmd_word2));

  // Behavioural reference model
  logic [31:0] m_ctrl, m_t0, m_t1;
  logic [11:0] m_st;
  bit          m_err;
  int          m_ph;   // 0 idle, 1 loading, 2 presenting, 3 handed off
  int          m_cnt;
  logic [31:0] m_w [3];

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00: return m_ctrl;
      8'h04: return m_t0;
      8'h0C: return m_t1;
      8'h14: return {m_err, 19'd0, m_st};
      8'h48: return m_w[0];
      8'h4C: return m_w[1];
      8'h50: return m_w[2];
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    automatic logic [31:0] d = bus_wdata;
    automatic logic [7:0]  a = bus_addr;
    automatic bit cmdw = bus_wr && (a == 8'h48 || a == 8'h4C || a == 8'h50);
    automatic bit rise = bus_wr && a == 8'h00 && d[28] && !m_ctrl[28];
    automatic bit fall = bus_wr && a == 8'h00 && !d[28] && m_ctrl[28];
    automatic bit acc  = cmdw && m_st[0] && m_ph == 1;
    automatic bit hsk  = m_ph == 2 && cmd_ready;
    if (!rst_n) begin
      m_ctrl = 32'hFFF; m_t0 = 0; m_t1 = 0; m_st = 0; m_err = 0;
      m_ph = 0; m_cnt = 0; m_w[0] = 0; m_w[1] = 0; m_w[2] = 0;
    end else begin
      if (bus_wr && a == 8'h14) m_st = m_st & ~d[11:0];
      m_st[11:1] = m_st[11:1] | evt_set[11:1];
      if (hsk || fall) m_st[0] = 1'b0;
      if (rise) m_st[0] = 1'b1;
      if (cmdw && !acc) m_err = 1;
      else if (bus_wr && a == 8'h14 && d[31]) m_err = 0;
      if (fall) begin m_ph = 0; m_cnt = 0; end
      else if (rise) begin m_ph = 1; m_cnt = 0; end
      else if (acc) begin
        m_w[m_cnt] = d;
        if (m_cnt == 2) begin m_ph = 2; m_cnt = 0; end
        else m_cnt++;
      end else if (hsk) m_ph = 3;
      if (bus_wr && a == 8'h00) m_ctrl = d;
      if (bus_wr && a == 8'h04) m_t0 = d;
      if (bus_wr && a == 8'h0C) m_t1 = d;
    end
    #5;
    if (rst_n) begin
      check("R5 irq", {31'd0, irq}, {31'd0, |(m_st & ~m_ctrl[11:0])});
      check("R8 cmd_valid", {31'd0, cmd_valid}, {31'd0, m_ph == 2});
      check("R10 run", {31'd0, run}, {31'd0, m_ctrl[28]});
      check("R2 timing0", timing0, m_t0);
      check("R2 readback", bus_rdata, m_read(bus_addr));
      if (m_ph == 2) begin
        check("R7 word0", cmd_word0, m_w[0]);
        check("R7 word1", cmd_word1, m_w[1]);
        check("R7 word2", cmd_word2, m_w[2]);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; evt_set = '0;
  endtask

  task automatic rdc(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_wr = 1'b0; evt_set = '0; bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic ev(input logic [11:0] v);
    @(negedge clk);
    bus_wr = 1'b0; evt_set = v;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rdc(8'h00, 32'h0000_0FFF, "R1 ctrl reset");
    check("R1 irq reset", {31'd0, irq}, 32'd0);
    rdc(8'h14, 32'h0, "R1 status reset");
    rdc(8'h04, 32'h0, "R1 timing reset");
    // R2 timing words
    wr(8'h04, 32'hA5A5_1234);
    wr(8'h0C, 32'h0000_BEEF);
    rdc(8'h04, 32'hA5A5_1234, "R2 timing0");
    rdc(8'h0C, 32'h0000_BEEF, "R2 timing1");
    check("R2 timing1 port", timing1, 32'h0000_BEEF);
    // R11 unmapped
    wr(8'h40, 32'hDEAD_0000);
    wr(8'h30, 32'h1);
    rdc(8'h40, 32'h0, "R11 data buffer");
    rdc(8'h30, 32'h0, "R11 unmapped");
    rdc(8'h00, 32'h0000_0FFF, "R11 ctrl untouched");
    // R9 command write before run
    wr(8'h48, 32'h1111_1111);
    rdc(8'h48, 32'h0, "R9 word untouched");
    rdc(8'h14, 32'h8000_0000, "R9 error set");
    wr(8'h14, 32'h8000_0000);
    rdc(8'h14, 32'h0, "R9 error cleared");
    // R3 events, bit 0 ignored
    ev(12'h109);
    rdc(8'h14, 32'h108, "R3 event bits");
    check("R5 masked irq", {31'd0, irq}, 32'd0);
    wr(8'h00, 32'h0000_0EF7);
    rdc(8'h14, 32'h108, "R3 sticky");
    check("R5 unmasked irq", {31'd0, irq}, 32'd1);
    // R4 write one to clear
    wr(8'h14, 32'h100);
    rdc(8'h14, 32'h008, "R4 w1c");
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h14; bus_wdata = 32'h008; evt_set = 12'h008;
    rdc(8'h14, 32'h008, "R4 set wins");
    wr(8'h14, 32'h008);
    rdc(8'h14, 32'h0, "R4 cleared");
    check("R5 irq low", {31'd0, irq}, 32'd0);
    // R6 run raises request
    wr(8'h00, 32'h1000_0FFE);
    rdc(8'h14, 32'h1, "R6 request");
    check("R6 irq", {31'd0, irq}, 32'd1);
    // R7/R8 load and present
    wr(8'h48, 32'hC0DE_0000);
    wr(8'h48, 32'hC0DE_0001);
    rdc(8'h48, 32'hC0DE_0000, "R7 word0");
    check("R8 not yet valid", {31'd0, cmd_valid}, 32'd0);
    wr(8'h48, 32'hC0DE_0002);
    rdc(8'h4C, 32'hC0DE_0001, "R7 word1");
    check("R8 valid", {31'd0, cmd_valid}, 32'd1);
    rdc(8'h50, 32'hC0DE_0002, "R7 word2");
    check("R8 held", {31'd0, cmd_valid}, 32'd1);
    wr(8'h48, 32'hBAD0_BAD0);
    rdc(8'h14, 32'h8000_0001, "R9 reject while presenting");
    check("R9 word0 kept", cmd_word0, 32'hC0DE_0000);
    @(negedge clk); cmd_ready = 1'b1;
    @(negedge clk); cmd_ready = 1'b0;
    check("R8 valid dropped", {31'd0, cmd_valid}, 32'd0);
    rdc(8'h14, 32'h8000_0000, "R8 request cleared");
    wr(8'h14, 32'h8000_0000);
    // R10 abort partial load
    wr(8'h00, 32'h0000_0FFE);
    wr(8'h00, 32'h1000_0FFE);
    wr(8'h4C, 32'h5555_0000);
    wr(8'h00, 32'h0000_0FFE);
    rdc(8'h14, 32'h0, "R10 request cleared");
    wr(8'h00, 32'h1000_0FFE);
    wr(8'h50, 32'h7777_0000);
    wr(8'h48, 32'h7777_0001);
    wr(8'h4C, 32'h7777_0002);
    rdc(8'h48, 32'h7777_0000, "R10 restart at word0");
    check("R7 alias order", cmd_word2, 32'h7777_0002);
    check("R8 valid again", {31'd0, cmd_valid}, 32'd1);
    wr(8'h00, 32'h0000_0FFE);
    rdc(8'h14, 32'h0, "R10 stop clears request");
    check("R10 valid dropped", {31'd0, cmd_valid}, 32'd0);
    @(negedge clk); cmd_ready = 1'b1;
    @(negedge clk); cmd_ready = 1'b0;
    check("R10 ready while idle", {31'd0, cmd_valid}, 32'd0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule